// File: doc/BRIEF.md
# I/O Page Select Generator

This block turns a processor physical address into the address driven onto a shared peripheral bus, together with a single I/O-page strobe. Peripheral registers live in a fixed 8 KB window at the very top of the current address space. Peripherals never decode the upper address bits. Each one compares only the low 16 address bits against its own register base, and only while the strobe is high.

Three address widths are supported: 16, 18 and 22 bits. A mapping-enable flag tells the block whether the processor is running with memory management active. With mapping on in the wider modes, a 16-bit address inside the top 8 KB is ordinary memory. Only the true top of the wide space selects peripherals. With mapping off, the processor behaves as a 16-bit machine.

A small bank of device comparators shows the device-side decode. All outputs come from one register stage, so they move together one clock after the inputs.

Top module: `iopage_sel`

## Requirements
- R1: Width mode uses the encoding 00 = 16-bit, 01 = 18-bit and 10 = 22-bit. Code 11 is illegal. For code 11, one cycle later `mode_err` is 1, `iop_sel` is 0, `bus_addr` is 0 and `dev_sel` is 0. For every legal code, `mode_err` is 0.
- R2: In 16-bit mode, `iop_sel` is the AND of address bits 15, 14 and 13, so it is set for every low-16 value at or above octal 160000. `bus_addr` carries address bits 15:0 with all higher bits zero. `map_en` has no effect in this mode.
- R3: In 18-bit mode with `map_en`=1, `iop_sel` is set only when address bits 17:0 are at or above octal 760000. `bus_addr` carries bits 17:0 with bits 21:18 zero.
- R4: In 22-bit mode with `map_en`=1, `iop_sel` is set only when the address is at or above octal 17760000. `bus_addr` carries all 22 bits.
- R5: In 18-bit or 22-bit mode with `map_en`=1, an address whose bits above 15 are zero never sets `iop_sel`, even when it lies in octal 160000..177777.
- R6: In 18-bit or 22-bit mode with `map_en`=0, the block behaves exactly as in 16-bit mode (R2).
- R7: `dev_sel[i]` is 1 exactly when `iop_sel` is 1 and address bits 15:1 equal bits 15:1 of device i's base. Address bits above 15 and bit 0 are ignored. Device i's base is `dev_base[16*i +: 16]`.
- R8: No bit of `dev_sel` is ever 1 while `iop_sel` is 0.
- R9: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge and all change in the same cycle. While `rst_n` is 0, every output is 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 22 | Processor physical address |
| width_mode | input | 2 | Address width select (00/01/10, 11 illegal) |
| map_en | input | 1 | Memory management active |
| dev_base | input | 32 | Register bases of the devices, 16 bits each |
| bus_addr | output | 22 | Registered bus address |
| iop_sel | output | 1 | Registered I/O-page strobe |
| mode_err | output | 1 | Registered illegal-mode flag |
| dev_sel | output | 2 | Registered per-device selects |

## Verification
The hardest case to reach is a wide mode with mapping enabled and an address sitting in the 16-bit I/O window with zero upper bits. This address looks like a peripheral access, yet it has to reach memory without asserting either the strobe or any device select. The stimulus places directed addresses that match a device base in their low 16 bits in exactly this case, and it also supplies the same low bits with the upper bits all ones in every mode. Random addresses are biased toward the top window, so that strobe and select edges appear often in all mode and mapping combinations.

// File: rtl/iopage_pkg.sv
// Shared types for the I/O page select generator.
package iopage_pkg;
    // Width mode encoding; the value 3 is illegal.
    typedef enum logic [1:0] {
        WM_16  = 2'b00,
        WM_18  = 2'b01,
        WM_22  = 2'b10,
        WM_BAD = 2'b11
    } width_mode_t;
endpackage

// File: rtl/iop_decode.sv
// Combinational decode of the I/O page strobe and the bus address.
// Assumes NARROW_W < MID_W < ADDR_W and PAGE_LSB < NARROW_W. With
// mapping off, the wide modes fall back to the narrow decode.
module iop_decode
    import iopage_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int MID_W    = 18,
    parameter int NARROW_W = 16,
    parameter int PAGE_LSB = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        mode,
    input  logic              map_en,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              strobe,
    output logic              err
);
    width_mode_t wm;
    assign wm = width_mode_t'(mode);

    // Pick the effective width and form the strobe from its top bits.
    always_comb begin
        bus_addr = '0;
        strobe   = 1'b0;
        err      = 1'b0;
        case (wm)
            WM_18: begin
                if (map_en) begin
                    bus_addr[MID_W-1:0] = addr[MID_W-1:0];
                    strobe = &addr[MID_W-1:PAGE_LSB];
                end else begin
                    bus_addr[NARROW_W-1:0] = addr[NARROW_W-1:0];
                    strobe = &addr[NARROW_W-1:PAGE_LSB];
                end
            end
            WM_22: begin
                if (map_en) begin
                    bus_addr = addr;
                    strobe   = &addr[ADDR_W-1:PAGE_LSB];
                end else begin
                    bus_addr[NARROW_W-1:0] = addr[NARROW_W-1:0];
                    strobe = &addr[NARROW_W-1:PAGE_LSB];
                end
            end
            WM_16: begin
                bus_addr[NARROW_W-1:0] = addr[NARROW_W-1:0];
                strobe = &addr[NARROW_W-1:PAGE_LSB];
            end
            default: err = 1'b1;
        endcase
    end
endmodule

// File: rtl/dev_match.sv
// Device-side register decode: one comparator per device on the low
// NARROW_W address bits, gated by the I/O page strobe. Bit 0 is ignored
// because bases are word aligned.
module dev_match #(
    parameter int ADDR_W   = 22,
    parameter int NARROW_W = 16,
    parameter int NUM_DEV  = 2
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        strobe,
    input  logic [NUM_DEV*NARROW_W-1:0] bases,
    output logic [NUM_DEV-1:0]          sel
);
    genvar i;
    generate
        for (i = 0; i < NUM_DEV; i++) begin : g_dev
            logic [NARROW_W-1:0] base_i;
            assign base_i = bases[i*NARROW_W +: NARROW_W];
            // Compare word address of the low bits against this base.
            always_comb begin
                sel[i] = strobe && (addr[NARROW_W-1:1] == base_i[NARROW_W-1:1]);
            end
        end
    endgenerate
endmodule

// File: rtl/iop_out_reg.sv
// Output register stage: captures address, strobe, error and selects on
// the same edge. Synchronous active-low reset clears everything.
module iop_out_reg #(
    parameter int ADDR_W  = 22,
    parameter int NUM_DEV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_d,
    input  logic               strobe_d,
    input  logic               err_d,
    input  logic [NUM_DEV-1:0] sel_d,
    output logic [ADDR_W-1:0]  bus_q,
    output logic               strobe_q,
    output logic               err_q,
    output logic [NUM_DEV-1:0] sel_q
);
    // Register all outputs together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q    <= '0;
            strobe_q <= 1'b0;
            err_q    <= 1'b0;
            sel_q    <= '0;
        end else begin
            bus_q    <= bus_d;
            strobe_q <= strobe_d;
            err_q    <= err_d;
            sel_q    <= sel_d;
        end
    end
endmodule

// File: rtl/iopage_sel_chk.sv
// Assertion checker for iopage_sel, bound into every instance.
// Assumes the default widths: 22-bit wide, 18-bit mid, 16-bit narrow.
module iopage_sel_chk #(
    parameter int ADDR_W  = 22,
    parameter int NUM_DEV = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     cpu_addr,
    input logic [1:0]            width_mode,
    input logic                  map_en,
    input logic [NUM_DEV*16-1:0] dev_base,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  iop_sel,
    input logic                  mode_err,
    input logic [NUM_DEV-1:0]    dev_sel
);
    // R8
    sel_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel != '0) |-> iop_sel);
    // R1
    illegal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (width_mode == 2'b11) |=> (mode_err && !iop_sel && bus_addr == '0));
    // R1
    err_blocks_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !iop_sel);
    // R2
    narrow_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (width_mode == 2'b00 && (&cpu_addr[15:13])) |=> iop_sel);
    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (width_mode == 2'b00) |=> (bus_addr[ADDR_W-1:16] == '0));
    // R5
    mapped_low_is_memory_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_en && width_mode != 2'b00 && cpu_addr[ADDR_W-1:16] == '0) |=> !iop_sel);
    // R4
    wide_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_en && width_mode == 2'b10 && (&cpu_addr[ADDR_W-1:13])) |=> iop_sel);
endmodule

bind iopage_sel iopage_sel_chk #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV)) chk_i (.*);

// File: rtl/iopage_sel.sv
// I/O page select generator top. Decodes the processor address into a bus
// address and an I/O-page strobe for 16/18/22-bit address widths, then
// runs the device comparators and registers everything in one stage.
// Assumes the checker's fixed widths match the defaults.
module iopage_sel #(
    parameter int ADDR_W   = 22,
    parameter int MID_W    = 18,
    parameter int NARROW_W = 16,
    parameter int PAGE_LSB = 13,
    parameter int NUM_DEV  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [1:0]                  width_mode,
    input  logic                        map_en,
    input  logic [NUM_DEV*NARROW_W-1:0] dev_base,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic                        iop_sel,
    output logic                        mode_err,
    output logic [NUM_DEV-1:0]          dev_sel
);
    logic [ADDR_W-1:0]  bus_c;
    logic               strobe_c;
    logic               err_c;
    logic [NUM_DEV-1:0] sel_c;

    iop_decode #(
        .ADDR_W(ADDR_W), .MID_W(MID_W), .NARROW_W(NARROW_W), .PAGE_LSB(PAGE_LSB)
    ) dec_i (
        .addr(cpu_addr), .mode(width_mode), .map_en(map_en),
        .bus_addr(bus_c), .strobe(strobe_c), .err(err_c)
    );

    dev_match #(
        .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .NUM_DEV(NUM_DEV)
    ) match_i (
        .addr(bus_c), .strobe(strobe_c), .bases(dev_base), .sel(sel_c)
    );

    iop_out_reg #(
        .ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV)
    ) oreg_i (
        .clk(clk), .rst_n(rst_n),
        .bus_d(bus_c), .strobe_d(strobe_c), .err_d(err_c), .sel_d(sel_c),
        .bus_q(bus_addr), .strobe_q(iop_sel), .err_q(mode_err), .sel_q(dev_sel)
    );
endmodule

// File: tb/iopage_sel_tb_top.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module iopage_sel_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] cpu_addr = '0;
    logic [1:0]  width_mode = '0;
    logic        map_en = 1'b0;
    logic [31:0] dev_base;
    logic [21:0] bus_addr;
    logic        iop_sel;
    logic        mode_err;
    logic [1:0]  dev_sel;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    localparam int BASE0 = 'o177560;
    localparam int BASE1 = 'o172340;

    iopage_sel dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .width_mode(width_mode),
        .map_en(map_en), .dev_base(dev_base), .bus_addr(bus_addr),
        .iop_sel(iop_sel), .mode_err(mode_err), .dev_sel(dev_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial dev_base = {BASE1[15:0], BASE0[15:0]};

    // Compare outputs with expected values and count the check.
    task automatic compare(input string tag, input int e_bus, input bit e_iop,
                           input bit e_err, input int e_sel);
        checks++;
        if (bus_addr !== e_bus[21:0] || iop_sel !== e_iop ||
            mode_err !== e_err || dev_sel !== e_sel[1:0]) begin
            errors++;
            $display("FAIL %s: got bus=%o iop=%0d err=%0d sel=%b, exp bus=%o iop=%0d err=%0d sel=%b",
                     tag, bus_addr, iop_sel, mode_err, dev_sel,
                     e_bus[21:0], e_iop, e_err, e_sel[1:0]);
        end
    endtask

    // Behavioural reference: thresholds in octal per requirement.
    task automatic model(input int a, input int m, input bit mp, output int e_bus,
                         output bit e_iop, output bit e_err, output int e_sel);
        int low;
        e_bus = 0; e_iop = 0; e_err = 0; e_sel = 0;
        low = a % 65536;
        if (m == 3) begin
            e_err = 1;
        end else if (m == 0 || !mp) begin
            e_bus = low;
            e_iop = (low >= 'o160000);
        end else if (m == 1) begin
            e_bus = a % 262144;
            e_iop = (e_bus >= 'o760000);
        end else begin
            e_bus = a;
            e_iop = (a >= 'o17760000);
        end
        if (e_iop && (low / 2) == (BASE0 / 2)) e_sel += 1;
        if (e_iop && (low / 2) == (BASE1 / 2)) e_sel += 2;
    endtask

    // Apply one vector, wait for the edge, then check one cycle later (R9).
    task automatic step(input int a, input int m, input bit mp, input string tag);
        int e_bus, e_sel;
        bit e_iop, e_err;
        cpu_addr = a[21:0];
        width_mode = m[1:0];
        map_en = mp;
        model(a, m, mp, e_bus, e_iop, e_err, e_sel);
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare(tag, e_bus, e_iop, e_err, e_sel);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: got cycles=%0d, exp fewer", cycles);
            finish_run();
        end
    end

    initial begin
        // R9 reset state
        cpu_addr = 22'o17777777; width_mode = 2'b00;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        compare("R9 reset", 0, 0, 0, 0);
        rst_n = 1'b1;

        // R2 narrow mode edges, map_en ignored, upper bits dropped
        step('o160000, 0, 0, "R2 page start");
        step('o157776, 0, 0, "R2 below page");
        step('o177777, 0, 1, "R2 top map_en");
        step('o17760000, 0, 1, "R2 upper dropped");
        // R3 mid mapped
        step('o760000, 1, 1, "R3 page start");
        step('o757776, 1, 1, "R3 below page");
        step('o17777776, 1, 1, "R3 upper dropped");
        // R4 wide mapped
        step('o17760000, 2, 1, "R4 page start");
        step('o17757776, 2, 1, "R4 below page");
        // R5 mapped low window is memory
        step('o160000, 1, 1, "R5 mid mem");
        step('o177560, 2, 1, "R5 wide mem dev0 low");
        step('o760000, 2, 1, "R5 wide mid page is mem");
        // R6 unmapped wide modes act narrow
        step('o160000, 2, 0, "R6 wide unmapped");
        step('o17577560, 1, 0, "R6 mid unmapped dev0");
        // R1 illegal
        step('o17777560, 3, 1, "R1 illegal");
        step('o17777560, 3, 0, "R1 illegal unmapped");
        // R7 device selects, bit 0 and upper bits ignored
        step('o177561, 0, 0, "R7 dev0 odd");
        step('o177562, 0, 0, "R7 dev0 next word");
        step('o17772340, 2, 1, "R7 dev1 wide");
        step('o772341, 1, 1, "R7 dev1 mid odd");
        step('o072340, 0, 0, "R7 R8 dev1 low no strobe");

        // R9 reset mid-run clears outputs
        cpu_addr = 22'o17777560; width_mode = 2'b10; map_en = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare("R9 mid reset", 0, 0, 0, 0);
        rst_n = 1'b1;

        // Random vectors biased toward the top window, tagged R8
        for (int i = 0; i < 400; i++) begin
            int a;
            int m;
            a = int'($urandom % 4194304);
            if ($urandom % 2) a = a | ('o17760000 >> (4 * ($urandom % 3)));
            if (($urandom % 4) == 0) a = (a & 'o17600000) | BASE0 | ($urandom % 2);
            m = int'($urandom % 4);
            step(a, m, bit'($urandom % 2), "R8 random");
        end
        finish_run();
    end
endmodule